// File: doc/BRIEF.md
# DMA Translation Fault Status Register

This block records faults reported by a DMA address translation unit. When the unit's table walker or its access check fails, it pulses a fault strobe together with a fault type, the requester identifier (bus number and device/function) and the 32-bit DMA address. The block latches these into one packed 64-bit status word. The first fault is kept until software acknowledges it. A fault that arrives while a record is held sets a sticky overflow flag and does not replace the record.

A level interrupt stays asserted while a record is present and reporting is enabled in the control register. Software reads the status word and acknowledges the fault by writing the word back with bit 62 cleared. The control register holds the reporting enable and a threshold field that is stored for the translation unit.

Top module: `dma_fault_status`

## Requirements
- R1: After a synchronous active-low reset the status word is all zero, `irq` is low, and the control word equals 0x100 shifted left by 10 (0x0000_0000_0004_0000), so reporting starts disabled.
- R2: A fault strobe while no record is held loads the status word one clock later. Bit 63 = 1 (record present), bit 62 = 1 (awaiting acknowledge), bits 61:59 = fault type, bits 52:37 = requester ID (bus in the upper byte, devfn in the lower byte), bits 31:0 = DMA address. All other bits are zero.
- R3: The fault type is stored unchanged. Codes 0..5 mean invalid first-level device entry, invalid second-level device entry, invalid first-level page entry, invalid second-level page entry, unauthorized access and illegal response. Codes 6 and 7 are reserved and are stored as given.
- R4: While a record is held and not acknowledged, later fault strobes leave bits 63:59, 52:37 and 31:0 unchanged.
- R5: A fault strobe while a record is held sets the sticky overflow flag at bit 58. Only an acknowledge or a reset clears it.
- R6: A write to the status word (`wr_ctrl` = 0) with bit 62 of the write data at 0 clears the whole status word one clock later. A status write with bit 62 at 1 has no effect.
- R7: `irq` is high exactly when status bit 63 and control bit 63 are both 1. It is never high while status bit 63 is 0.
- R8: A control write (`wr_ctrl` = 1) stores bit 63 (reporting enable) and bits 21:10 (threshold). All other control bits read as zero.
- R9: When an acknowledge and a fault strobe fall in the same cycle, the new fault is captured as in R2, with overflow 0.
- R10: A control write leaves the status word unchanged, and a status write leaves the control word unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flt_strobe | input | 1 | One-cycle fault report from the translation unit |
| flt_kind | input | 3 | Fault type code |
| flt_reqid | input | 16 | Requester ID, bus in the upper byte and devfn in the lower byte |
| flt_addr | input | 32 | Faulting DMA address |
| wr_en | input | 1 | Register write strobe |
| wr_ctrl | input | 1 | Write target: 1 = control word, 0 = status word |
| wr_data | input | 64 | Write data |
| status_word | output | 64 | Packed fault status word |
| ctrl_word | output | 64 | Control word |
| irq | output | 1 | Level interrupt |

## Verification
On every cycle the assertions check four things: a capture into an empty register, the freezing of a held record together with the setting of overflow, the clearing of the word after an acknowledge, and the stability of the control word when nothing writes it. The bench covers what depends on whole sequences. It sweeps every fault type code against several requester and address patterns, checks the reset values, and toggles the interrupt enable on both sides of a fault. It also checks that an acknowledge with bit 62 set is ignored and that an acknowledge coinciding with a new fault keeps the new fault.

// File: rtl/dfs_pkg.sv
// Package: field widths and bit positions of the fault status and control words.
// Assumes a 64-bit register width; the positions are part of the software contract.
package dfs_pkg;
    localparam int unsigned WORD_W    = 64;
    localparam int unsigned KIND_W    = 3;
    localparam int unsigned REQID_W   = 16;
    localparam int unsigned ADDR_W    = 32;
    localparam int unsigned THR_W     = 12;

    localparam int unsigned ST_VALID  = 63;
    localparam int unsigned ST_HOLD   = 62;
    localparam int unsigned ST_KIND_L = 59;
    localparam int unsigned ST_OVF    = 58;
    localparam int unsigned ST_RID_L  = 37;
    localparam int unsigned ST_ADDR_L = 0;

    localparam int unsigned CT_EN     = 63;
    localparam int unsigned CT_THR_L  = 10;

    typedef enum logic [KIND_W-1:0] {
        FK_DEV_L1  = 3'd0,
        FK_DEV_L2  = 3'd1,
        FK_PAGE_L1 = 3'd2,
        FK_PAGE_L2 = 3'd3,
        FK_UNAUTH  = 3'd4,
        FK_BADRESP = 3'd5
    } fault_kind_e;

    typedef struct packed {
        logic               present;
        logic               pending;
        logic [KIND_W-1:0]  kind;
        logic               ovf;
        logic [REQID_W-1:0] reqid;
        logic [ADDR_W-1:0]  addr;
    } fault_rec_t;
endpackage

// File: rtl/dfs_capture.sv
// Module: dfs_capture
// Holds the first fault record until software acknowledges it; later faults only set
// a sticky overflow flag. An acknowledge in the same cycle as a fault makes room for it.
// Assumes flt_strobe is a single-cycle pulse per fault and ack is a single-cycle strobe.
module dfs_capture
    import dfs_pkg::*;
#(
    parameter int unsigned P_KIND_W  = KIND_W,
    parameter int unsigned P_REQID_W = REQID_W,
    parameter int unsigned P_ADDR_W  = ADDR_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 flt_strobe,
    input  logic [P_KIND_W-1:0]  flt_kind,
    input  logic [P_REQID_W-1:0] flt_reqid,
    input  logic [P_ADDR_W-1:0]  flt_addr,
    input  logic                 ack,
    output fault_rec_t           rec
);
    fault_rec_t rec_q;
    fault_rec_t fresh;

    // Build the record a newly accepted fault would load.
    always_comb begin
        fresh         = '0;
        fresh.present = 1'b1;
        fresh.pending = 1'b1;
        fresh.kind    = flt_kind;
        fresh.reqid   = flt_reqid;
        fresh.addr    = flt_addr;
    end

    // Record register: first fault wins, acknowledge clears, a collision sets overflow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_q <= '0;
        end else if (flt_strobe && (ack || !rec_q.present)) begin
            rec_q <= fresh;
        end else if (ack) begin
            rec_q <= '0;
        end else if (flt_strobe) begin
            rec_q.ovf <= 1'b1;
        end
    end

    assign rec = rec_q;

    // R2
    capture_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_strobe && !rec_q.present && !ack) |=>
        (rec_q.present && rec_q.pending && !rec_q.ovf && rec_q.kind == $past(flt_kind)
         && rec_q.reqid == $past(flt_reqid) && rec_q.addr == $past(flt_addr)));

    // R4
    first_fault_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_q.present && !ack) |=>
        ($stable(rec_q.kind) && $stable(rec_q.reqid) && $stable(rec_q.addr) && rec_q.present));

    // R5
    overflow_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_q.present && !ack && flt_strobe) |=> rec_q.ovf);

    // R6
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !flt_strobe) |=> (rec_q == '0));
endmodule

// File: rtl/dfs_control.sv
// Module: dfs_control
// Control register: the reporting enable and the threshold field, written whole on a
// control write. Assumes the threshold is consumed by the translation unit, not here.
module dfs_control
    import dfs_pkg::*;
#(
    parameter int unsigned P_THR_W   = THR_W,
    parameter int unsigned P_THR_RST = 'h100
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic               en_in,
    input  logic [P_THR_W-1:0] thr_in,
    output logic               en,
    output logic [P_THR_W-1:0] thr
);
    localparam logic [P_THR_W-1:0] THR_RST = P_THR_W'(P_THR_RST);

    // Enable and threshold storage with their reset values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en  <= 1'b0;
            thr <= THR_RST;
        end else if (wr) begin
            en  <= en_in;
            thr <= thr_in;
        end
    end

    // R10
    ctrl_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> ($stable(en) && $stable(thr)));
endmodule

// File: rtl/dma_fault_status.sv
// Module: dma_fault_status
// Top of the fault status block: decodes register writes, packs the status and control
// words and drives the level interrupt. Assumes one register write per cycle at most.
module dma_fault_status
    import dfs_pkg::*;
#(
    parameter int unsigned P_THR_W   = THR_W,
    parameter int unsigned P_THR_RST = 'h100
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flt_strobe,
    input  logic [KIND_W-1:0]  flt_kind,
    input  logic [REQID_W-1:0] flt_reqid,
    input  logic [ADDR_W-1:0]  flt_addr,
    input  logic               wr_en,
    input  logic               wr_ctrl,
    input  logic [WORD_W-1:0]  wr_data,
    output logic [WORD_W-1:0]  status_word,
    output logic [WORD_W-1:0]  ctrl_word,
    output logic               irq
);
    fault_rec_t         rec;
    logic               ack;
    logic               ctl_wr;
    logic               en;
    logic [P_THR_W-1:0] thr;

    // Write decode: a status write acknowledges only when bit 62 is written as zero.
    always_comb begin
        ack    = wr_en && !wr_ctrl && !wr_data[ST_HOLD];
        ctl_wr = wr_en && wr_ctrl;
    end

    dfs_capture u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .flt_strobe (flt_strobe),
        .flt_kind   (flt_kind),
        .flt_reqid  (flt_reqid),
        .flt_addr   (flt_addr),
        .ack        (ack),
        .rec        (rec)
    );

    dfs_control #(
        .P_THR_W   (P_THR_W),
        .P_THR_RST (P_THR_RST)
    ) u_control (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (ctl_wr),
        .en_in  (wr_data[CT_EN]),
        .thr_in (wr_data[CT_THR_L +: P_THR_W]),
        .en     (en),
        .thr    (thr)
    );

    // Pack the status word; unused bits stay zero.
    always_comb begin
        status_word                              = '0;
        status_word[ST_VALID]                    = rec.present;
        status_word[ST_HOLD]                     = rec.pending;
        status_word[ST_KIND_L +: KIND_W]         = rec.kind;
        status_word[ST_OVF]                      = rec.ovf;
        status_word[ST_RID_L +: REQID_W]         = rec.reqid;
        status_word[ST_ADDR_L +: ADDR_W]         = rec.addr;
    end

    // Pack the control word; unused bits stay zero.
    always_comb begin
        ctrl_word                        = '0;
        ctrl_word[CT_EN]                 = en;
        ctrl_word[CT_THR_L +: P_THR_W]   = thr;
    end

    // Level interrupt while a record is present and reporting is enabled.
    assign irq = rec.present && en;

    // R7
    irq_drops_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !flt_strobe) |=> !irq);
endmodule

// File: tb/dma_fault_status_bench.sv
// Bench: sweeps fault codes and ID/address patterns and computes expected words.
module dma_fault_status_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        flt_strobe;
    logic [2:0]  flt_kind;
    logic [15:0] flt_reqid;
    logic [31:0] flt_addr;
    logic        wr_en;
    logic        wr_ctrl;
    logic [63:0] wr_data;
    logic [63:0] status_word;
    logic [63:0] ctrl_word;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_fault_status u_dma_fault_status (
        .clk(clk), .rst_n(rst_n), .flt_strobe(flt_strobe), .flt_kind(flt_kind),
        .flt_reqid(flt_reqid), .flt_addr(flt_addr), .wr_en(wr_en), .wr_ctrl(wr_ctrl),
        .wr_data(wr_data), .status_word(status_word), .ctrl_word(ctrl_word), .irq(irq)
    );

    function automatic logic [63:0] exp_word(input logic [2:0] k, input logic [15:0] id,
                                             input logic [31:0] a, input logic ovf);
        return (64'd1 << 63) | (64'd1 << 62) | (64'(k) << 59) | (64'(ovf) << 58)
             | (64'(id) << 37) | 64'(a);
    endfunction

    task automatic chk64(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step;
        @(posedge clk);
        #1;
        flt_strobe = 1'b0;
        wr_en      = 1'b0;
    endtask

    task automatic fault(input logic [2:0] k, input logic [15:0] id, input logic [31:0] a);
        flt_strobe = 1'b1; flt_kind = k; flt_reqid = id; flt_addr = a;
    endtask

    task automatic wr(input logic c, input logic [63:0] d);
        wr_en = 1'b1; wr_ctrl = c; wr_data = d;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] ids [4];
        logic [31:0] adrs [4];
        ids[0] = 16'h0000; ids[1] = 16'hFFFF; ids[2] = 16'h1A2B; ids[3] = 16'h8001;
        adrs[0] = 32'h0000_0000; adrs[1] = 32'hFFFF_FFFF;
        adrs[2] = 32'hDEAD_2000; adrs[3] = 32'h0000_1FF8;
        rst_n = 1'b0; flt_strobe = 0; flt_kind = 0; flt_reqid = 0; flt_addr = 0;
        wr_en = 0; wr_ctrl = 0; wr_data = 0;
        step; step;
        rst_n = 1'b1;
        // R1 reset values
        chk64("R1 status", status_word, 64'd0);
        chk64("R1 ctrl", ctrl_word, 64'h0000_0000_0004_0000);
        chk64("R1 irq", 64'(irq), 64'd0);

        // R2 R3 sweep of codes and patterns with acknowledge between
        for (int k = 0; k < 8; k++) begin
            for (int p = 0; p < 4; p++) begin
                fault(3'(k), ids[p], adrs[(p + k) % 4]);
                step;
                chk64("R2 R3 capture", status_word, exp_word(3'(k), ids[p], adrs[(p + k) % 4], 1'b0));
                chk64("R7 irq disabled", 64'(irq), 64'd0);
                wr(1'b0, status_word & ~(64'd1 << 62));
                step;
                chk64("R6 ack clears", status_word, 64'd0);
            end
        end

        // R8 control write, reserved bits dropped
        wr(1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
        step;
        chk64("R8 ctrl all ones", ctrl_word, (64'd1 << 63) | (64'hFFF << 10));
        chk64("R7 irq no record", 64'(irq), 64'd0);
        wr(1'b1, (64'd1 << 63) | (64'h2A5 << 10));
        step;
        chk64("R8 ctrl value", ctrl_word, (64'd1 << 63) | (64'h2A5 << 10));

        // R7 irq follows record and enable; R4 R5 first fault held
        fault(3'd3, 16'h0310, 32'h1234_5000);
        step;
        chk64("R7 irq on", 64'(irq), 64'd1);
        fault(3'd5, 16'h7777, 32'hAAAA_0000);
        step;
        chk64("R4 R5 held with overflow", status_word, exp_word(3'd3, 16'h0310, 32'h1234_5000, 1'b1));
        step;
        chk64("R5 overflow sticky", status_word, exp_word(3'd3, 16'h0310, 32'h1234_5000, 1'b1));
        // R6 write with bit 62 set is ignored
        wr(1'b0, 64'hFFFF_FFFF_FFFF_FFFF);
        step;
        chk64("R6 ignored write", status_word, exp_word(3'd3, 16'h0310, 32'h1234_5000, 1'b1));
        // R10 control write leaves status alone
        wr(1'b1, 64'd0);
        step;
        chk64("R10 status kept", status_word, exp_word(3'd3, 16'h0310, 32'h1234_5000, 1'b1));
        chk64("R7 irq disabled", 64'(irq), 64'd0);
        wr(1'b1, 64'd1 << 63);
        step;
        chk64("R7 irq re-enabled", 64'(irq), 64'd1);
        // R9 acknowledge and new fault together
        wr(1'b0, 64'd0);
        fault(3'd1, 16'h4242, 32'h0BAD_F00D);
        step;
        chk64("R9 collision", status_word, exp_word(3'd1, 16'h4242, 32'h0BAD_F00D, 1'b0));
        chk64("R10 ctrl kept", ctrl_word, 64'd1 << 63);
        wr(1'b0, 64'd0);
        step;
        chk64("R6 final clear", status_word, 64'd0);
        chk64("R7 irq off", 64'(irq), 64'd0);

        // R1 reset mid-record
        fault(3'd4, 16'h0101, 32'h0000_0040);
        step;
        rst_n = 1'b0;
        step;
        rst_n = 1'b1;
        chk64("R1 status after reset", status_word, 64'd0);
        chk64("R1 ctrl after reset", ctrl_word, 64'h0000_0000_0004_0000);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule